// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block is one copy engine that moves payload between two descriptor rings kept in a local word-addressed memory. A producer fills source descriptors and advances a source write index. A consumer posts empty destination buffers and advances a destination write index. For each destination buffer the engine copies one source buffer, or a chain of gathered source buffers, into that buffer. It then writes the total byte count and the returned flags into the destination descriptor, advances its read indices and raises a one-cycle completion pulse.

Software reaches the engine through a small register port that holds the ring bases, ring sizes, write indices and the per-descriptor length limit, and reads back the two read indices. All descriptor and payload traffic goes through a single synchronous memory port. Read data on that port returns one cycle after the request.

Top module: `desc_copy_engine`

## Requirements
- R1: While reset is held and right after it, both read indices read 0, `mem_req` is low and `copy_done` is low.
- R2: A descriptor takes two words at `base + 8*index`. The first word is the buffer byte address. The second word holds the byte count in bits 15:0 and the flags in bits 31:16, with gather at bit 16, byte swap at bit 17 and the transfer tag at bits 31:20.
- R3: No transfer starts while the source read index equals the source write index, or while the destination read index equals the destination write index.
- R4: The payload words of a source buffer are copied in order to consecutive words of the destination buffer. The count field written back equals the number of bytes copied (lengths are multiples of 4).
- R5: A chain of source descriptors whose gather bit is set, ended by the first one with gather clear, fills one destination buffer back to back. The chain produces one completion and advances the source read index by the chain length and the destination read index by one.
- R6: The bytes taken from one source descriptor are limited to the length-limit register. Destination words beyond the copied data stay untouched.
- R7: A source descriptor with its swap bit set has every 32-bit word reversed in byte order as it is copied. Other descriptors are copied unchanged.
- R8: The flags written back carry the tag of the last descriptor of the chain and have the swap bit set if any part was swapped. The gather bit and bits 19:18 of the word are zero.
- R9: The count word, at destination descriptor address + 4, is the last store of a transfer and is written in the cycle of the completion pulse.
- R10: Read indices wrap modulo the ring size, and the source read index never passes the source write index.
- R11: `copy_done` is high for exactly one cycle per completed destination descriptor.
- R12: A ring size of zero keeps any new transfer from starting. Restoring the size resumes pending work.
- R13: Register offsets: 0 source base, 1 source entries, 2 source write index, 3 source read index (read-only), 4 destination base, 5 destination entries, 6 destination write index, 7 destination read index (read-only), 8 length limit in bytes. `reg_rdata` returns the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |
| copy_done | output | 1 | One-cycle completion pulse |

## Verification
The checks compare the read indices with the raw write-index registers. They therefore rely on software writing write indices that are already below the ring size, and on ring sizes being powers of two of at least two. They also rely on the memory returning read data exactly one cycle after the request. The bench keeps to these limits in three ways: it uses rings of four entries, writes every index modulo four, and lets each staged transfer drain before it reuses descriptor slots. It also changes the length limit and ring size only while the engine is idle.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam int LEN_W        = 16;
  localparam int META_W       = 12;
  localparam int DESC_GATHER  = 16;
  localparam int DESC_SWAP    = 17;
  localparam int DESC_META_LO = 20;

  localparam logic [3:0] RA_SRC_BASE = 4'd0;
  localparam logic [3:0] RA_SRC_SIZE = 4'd1;
  localparam logic [3:0] RA_SRC_WR   = 4'd2;
  localparam logic [3:0] RA_SRC_RD   = 4'd3;
  localparam logic [3:0] RA_DST_BASE = 4'd4;
  localparam logic [3:0] RA_DST_SIZE = 4'd5;
  localparam logic [3:0] RA_DST_WR   = 4'd6;
  localparam logic [3:0] RA_DST_RD   = 4'd7;
  localparam logic [3:0] RA_MAX_LEN  = 4'd8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DDESC, ST_SDESC0, ST_SDESC1, ST_RDQ, ST_RDW, ST_NEXT, ST_GWAIT, ST_WB
  } ce_state_e;

  function automatic logic [31:0] ring_next(input logic [31:0] idx, input logic [31:0] mask);
    return (idx + 32'd1) & mask;
  endfunction

  function automatic logic [31:0] desc_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + (idx << 3);
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [LEN_W-1:0] clip_len(input logic [LEN_W-1:0] n, input logic [LEN_W-1:0] lim);
    return (n > lim) ? lim : n;
  endfunction
endpackage

// File: rtl/ce_regs.sv
module ce_regs import ce_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [IDX_W-1:0] src_rd,
  input  logic [IDX_W-1:0] dst_rd,
  output logic [31:0]      src_base,
  output logic [31:0]      dst_base,
  output logic [IDX_W:0]   src_size,
  output logic [IDX_W:0]   dst_size,
  output logic [IDX_W-1:0] src_wr,
  output logic [IDX_W-1:0] dst_wr,
  output logic [LEN_W-1:0] max_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
      src_size <= '0;
      dst_size <= '0;
      src_wr   <= '0;
      dst_wr   <= '0;
      max_len  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_SRC_BASE: src_base <= reg_wdata;
        RA_SRC_SIZE: src_size <= reg_wdata[IDX_W:0];
        RA_SRC_WR:   src_wr   <= reg_wdata[IDX_W-1:0];
        RA_DST_BASE: dst_base <= reg_wdata;
        RA_DST_SIZE: dst_size <= reg_wdata[IDX_W:0];
        RA_DST_WR:   dst_wr   <= reg_wdata[IDX_W-1:0];
        RA_MAX_LEN:  max_len  <= reg_wdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RA_SRC_BASE: reg_rdata = src_base;
      RA_SRC_SIZE: reg_rdata = 32'(src_size);
      RA_SRC_WR:   reg_rdata = 32'(src_wr);
      RA_SRC_RD:   reg_rdata = 32'(src_rd);
      RA_DST_BASE: reg_rdata = dst_base;
      RA_DST_SIZE: reg_rdata = 32'(dst_size);
      RA_DST_WR:   reg_rdata = 32'(dst_wr);
      RA_DST_RD:   reg_rdata = 32'(dst_rd);
      RA_MAX_LEN:  reg_rdata = 32'(max_len);
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ce_rd_index.sv
module ce_rd_index import ce_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [IDX_W-1:0] mask,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= IDX_W'(ring_next(32'(idx), 32'(mask)));
  end
endmodule

// File: rtl/ce_engine.sv
module ce_engine import ce_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      src_base,
  input  logic [31:0]      dst_base,
  input  logic [IDX_W:0]   src_size,
  input  logic [IDX_W:0]   dst_size,
  input  logic [IDX_W-1:0] src_wr,
  input  logic [IDX_W-1:0] dst_wr,
  input  logic [IDX_W-1:0] src_rd,
  input  logic [IDX_W-1:0] dst_rd,
  input  logic [LEN_W-1:0] max_len,
  input  logic [31:0]      mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic             start,
  output logic             src_adv,
  output logic             dst_adv,
  output logic             copy_done,
  output logic [IDX_W-1:0] src_mask,
  output logic [IDX_W-1:0] dst_mask
);
  ce_state_e         state;
  logic [31:0]       sptr, dptr;
  logic [LEN_W-1:0]  words_left, total;
  logic [META_W-1:0] meta;
  logic              swap_cur, swap_any, gather_cur;

  logic [IDX_W:0]    s_m1, d_m1;
  logic [IDX_W-1:0]  smask_now, dmask_now;
  logic              go, src_avail;
  logic [31:0]       s_desc, d_desc;
  logic [LEN_W-1:0]  clip_bytes, clip_words;
  logic [15:0]       flags_out;

  assign s_m1       = src_size - (IDX_W+1)'(1);
  assign d_m1       = dst_size - (IDX_W+1)'(1);
  assign smask_now  = s_m1[IDX_W-1:0];
  assign dmask_now  = d_m1[IDX_W-1:0];
  assign go         = (src_size != '0) && (dst_size != '0) &&
                      (src_rd != (src_wr & smask_now)) && (dst_rd != (dst_wr & dmask_now));
  assign src_avail  = src_rd != (src_wr & src_mask);
  assign s_desc     = desc_addr(src_base, 32'(src_rd));
  assign d_desc     = desc_addr(dst_base, 32'(dst_rd));
  assign clip_bytes = clip_len(mem_rdata[LEN_W-1:0], max_len);
  assign clip_words = clip_bytes >> 2;
  assign flags_out  = {meta, 2'b00, swap_any, 1'b0};

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    start     = 1'b0;
    src_adv   = 1'b0;
    dst_adv   = 1'b0;
    copy_done = 1'b0;
    case (state)
      ST_IDLE:   begin mem_req = go; mem_addr = d_desc; start = go; end
      ST_DDESC:  begin mem_req = 1'b1; mem_addr = s_desc; end
      ST_SDESC0: begin mem_req = 1'b1; mem_addr = s_desc + 32'd4; end
      ST_RDQ:    begin mem_req = 1'b1; mem_addr = sptr; end
      ST_RDW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dptr;
        mem_wdata = swap_cur ? bswap32(mem_rdata) : mem_rdata;
      end
      ST_NEXT:   src_adv = 1'b1;
      ST_GWAIT:  begin mem_req = src_avail; mem_addr = s_desc; end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = d_desc + 32'd4;
        mem_wdata = {flags_out, total};
        dst_adv   = 1'b1;
        copy_done = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sptr       <= '0;
      dptr       <= '0;
      words_left <= '0;
      total      <= '0;
      meta       <= '0;
      swap_cur   <= 1'b0;
      swap_any   <= 1'b0;
      gather_cur <= 1'b0;
      src_mask   <= '0;
      dst_mask   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          src_mask <= smask_now;
          dst_mask <= dmask_now;
          total    <= '0;
          swap_any <= 1'b0;
          state    <= ST_DDESC;
        end
        ST_DDESC:  begin dptr <= mem_rdata; state <= ST_SDESC0; end
        ST_SDESC0: begin sptr <= mem_rdata; state <= ST_SDESC1; end
        ST_SDESC1: begin
          meta       <= mem_rdata[DESC_META_LO +: META_W];
          swap_cur   <= mem_rdata[DESC_SWAP];
          swap_any   <= swap_any | mem_rdata[DESC_SWAP];
          gather_cur <= mem_rdata[DESC_GATHER];
          words_left <= clip_words;
          state      <= (clip_words == '0) ? ST_NEXT : ST_RDQ;
        end
        ST_RDQ: state <= ST_RDW;
        ST_RDW: begin
          dptr       <= dptr + 32'd4;
          sptr       <= sptr + 32'd4;
          words_left <= words_left - LEN_W'(1);
          total      <= total + LEN_W'(4);
          state      <= (words_left == LEN_W'(1)) ? ST_NEXT : ST_RDQ;
        end
        ST_NEXT:  state <= gather_cur ? ST_GWAIT : ST_WB;
        ST_GWAIT: if (src_avail) state <= ST_SDESC0;
        ST_WB:    state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_copy_engine.sv
module desc_copy_engine import ce_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        copy_done
);
  logic [31:0]      src_base, dst_base;
  logic [IDX_W:0]   src_size, dst_size;
  logic [IDX_W-1:0] src_wr, dst_wr, src_rd, dst_rd, src_mask, dst_mask;
  logic [LEN_W-1:0] max_len;
  logic             eng_start, src_adv, dst_adv;

  ce_regs #(.IDX_W(IDX_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .src_rd, .dst_rd, .src_base, .dst_base, .src_size, .dst_size,
    .src_wr, .dst_wr, .max_len
  );

  ce_rd_index #(.IDX_W(IDX_W)) u_src_idx (
    .clk, .rst_n, .adv(src_adv), .mask(src_mask), .idx(src_rd)
  );

  ce_rd_index #(.IDX_W(IDX_W)) u_dst_idx (
    .clk, .rst_n, .adv(dst_adv), .mask(dst_mask), .idx(dst_rd)
  );

  ce_engine #(.IDX_W(IDX_W)) u_engine (
    .clk, .rst_n, .src_base, .dst_base, .src_size, .dst_size,
    .src_wr, .dst_wr, .src_rd, .dst_rd, .max_len, .mem_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .start(eng_start), .src_adv, .dst_adv, .copy_done, .src_mask, .dst_mask
  );
endmodule

// File: rtl/ce_checker.sv
module ce_checker #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             src_adv,
  input logic             dst_adv,
  input logic             copy_done,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_addr_b2,
  input logic [IDX_W-1:0] src_rd,
  input logic [IDX_W-1:0] src_wr,
  input logic [IDX_W-1:0] dst_rd,
  input logic [IDX_W-1:0] dst_wr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!mem_req && !copy_done));

  // R3
  start_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (src_rd != src_wr) && (dst_rd != dst_wr));

  // R3
  dst_no_overtake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_adv |-> dst_rd != dst_wr);

  // R10
  src_no_overtake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_adv |-> src_rd != src_wr);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |=> !copy_done);

  // R11
  done_moves_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |=> dst_rd != $past(dst_rd));

  // R9
  done_writes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> (mem_req && mem_we && mem_addr_b2));
endmodule

bind desc_copy_engine ce_checker #(.IDX_W(IDX_W)) u_ce_chk (
  .clk(clk), .rst_n(rst_n), .start(eng_start), .src_adv(src_adv), .dst_adv(dst_adv),
  .copy_done(copy_done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr_b2(mem_addr[2]),
  .src_rd(src_rd), .src_wr(src_wr), .dst_rd(dst_rd), .dst_wr(dst_wr)
);

// File: tb/desc_copy_engine_bench.sv
module desc_copy_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, copy_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  desc_copy_engine u_desc_copy_engine (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .copy_done
  );

  logic [31:0] mem [0:2047];
  always @(posedge clk) begin
    if (mem_req && mem_we)  mem[mem_addr[12:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[12:2]];
  end

  typedef struct {
    int unsigned cnt_addr;
    int unsigned dbuf;
    logic [31:0] cnt;
    int          n;
    logic [31:0] w [16];
    logic [63:0] tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  int checks = 0, fails = 0, done_cnt = 0;
  int s_wr = 0, d_wr = 0, slot = 0;
  int unsigned maxb = 64;

  function automatic logic [31:0] flip(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] dgen(input int s, input int k, input int j);
    return {8'(s), 8'(k), 16'(j * 257 + 3)};
  endfunction

  task automatic check(input logic [63:0] req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // driver: stages one destination buffer and a chain of nd source descriptors
  task automatic stage(input int nd, input int unsigned lens[4], input bit swp[4],
                       input int unsigned meta, input logic [63:0] tag,
                       input bit bump_src, input bit bump_dst);
    exp_t e;
    int unsigned dbuf, sbuf, total, c;
    bit sany;
    logic [15:0] fl;
    dbuf = 32'h1000 + (slot % 8) * 32'h80;
    for (int j = 0; j < 32; j++) mem[(dbuf >> 2) + j] = 32'hA5A5_0000 | j;
    e.n = 0; total = 0; sany = 0;
    for (int k = 0; k < nd; k++) begin
      sbuf = 32'h400 + (slot % 8) * 32'h100 + k * 32'h40;
      for (int j = 0; j < int'(lens[k] / 4); j++) mem[(sbuf >> 2) + j] = dgen(slot, k, j);
      fl = {12'(meta + k), 2'b00, swp[k], (k < nd - 1) ? 1'b1 : 1'b0};
      mem[(s_wr * 8) >> 2]       = sbuf;
      mem[((s_wr * 8) >> 2) + 1] = {fl, 16'(lens[k])};
      c = (lens[k] < maxb) ? lens[k] : maxb;
      for (int j = 0; j < int'(c / 4); j++) begin
        e.w[e.n] = swp[k] ? flip(dgen(slot, k, j)) : dgen(slot, k, j);
        e.n++;
      end
      total += c;
      sany  |= swp[k];
      s_wr   = (s_wr + 1) % 4;
    end
    e.cnt      = {12'(meta + nd - 1), 2'b00, sany, 1'b0, 16'(total)};
    e.cnt_addr = 32'h100 + d_wr * 8 + 4;
    e.dbuf     = dbuf;
    e.tag      = tag;
    mem[(32'h100 + d_wr * 8) >> 2]       = dbuf;
    mem[((32'h100 + d_wr * 8) >> 2) + 1] = 32'h0;
    d_wr = (d_wr + 1) % 4;
    slot++;
    sb.push_back(e);
    if (bump_dst) reg_write(4'd6, 32'(d_wr));
    if (bump_src) reg_write(4'd2, 32'(s_wr));
  endtask

  // monitor: pops the expected item at each completion pulse
  always @(negedge clk) begin
    if (rst_n && copy_done) begin
      done_cnt++;
      if (sb.size() == 0) begin
        check("R11", 32'd1, 32'd0);
      end else begin
        mon_e = sb.pop_front();
        check("R9", mem_addr, mon_e.cnt_addr);
        check(mon_e.tag, mem_wdata, mon_e.cnt);
        for (int j = 0; j < mon_e.n; j++)
          check(mon_e.tag, mem[(mon_e.dbuf >> 2) + j], mon_e.w[j]);
        check("R6", mem[(mon_e.dbuf >> 2) + mon_e.n], 32'hA5A5_0000 | mon_e.n);
      end
    end
  end

  task automatic drain();
    int t = 0;
    while (sb.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (t == 2000) check("DRAIN", 32'(sb.size()), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int d0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", 32'(mem_req), 32'd0);
    check("R1", 32'(copy_done), 32'd0);
    reg_read(4'd3, rd); check("R1", rd, 32'd0);
    reg_read(4'd7, rd); check("R1", rd, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(mem_req), 32'd0);

    reg_write(4'd0, 32'h0);
    reg_write(4'd1, 32'd4);
    reg_write(4'd4, 32'h100);
    reg_write(4'd5, 32'd4);
    reg_write(4'd8, 32'd64);
    reg_read(4'd5, rd); check("R13", rd, 32'd4);

    // R3: source posted, no destination posted
    d0 = done_cnt;
    stage(1, '{8, 0, 0, 0}, '{0, 0, 0, 0}, 7, "R2", 1'b1, 1'b0);
    repeat (30) @(negedge clk);
    check("R3", 32'(done_cnt), 32'(d0));
    reg_read(4'd3, rd); check("R3", rd, 32'd0);
    reg_write(4'd6, 32'(d_wr));
    drain();
    reg_read(4'd3, rd); check("R13", rd, 32'd1);
    reg_read(4'd7, rd); check("R13", rd, 32'd1);

    // R7: byte swap
    stage(1, '{12, 0, 0, 0}, '{1, 0, 0, 0}, 5, "R7", 1'b1, 1'b1);
    drain();

    // R5 / R8: three-entry gather chain, swap on the middle one
    d0 = done_cnt;
    stage(3, '{8, 4, 12, 0}, '{0, 1, 0, 0}, 9, "R8", 1'b1, 1'b1);
    drain();
    check("R11", 32'(done_cnt), 32'(d0 + 1));
    reg_read(4'd3, rd); check("R5", rd, 32'(s_wr));
    reg_read(4'd7, rd); check("R5", rd, 32'(d_wr));

    // R6: length limit
    maxb = 8;
    reg_write(4'd8, 32'd8);
    stage(1, '{16, 0, 0, 0}, '{0, 0, 0, 0}, 3, "R6", 1'b1, 1'b1);
    drain();
    maxb = 64;
    reg_write(4'd8, 32'd64);

    // R10: indices wrap around the four-entry rings
    for (int i = 0; i < 3; i++) begin
      stage(1, '{4 * (i + 1), 0, 0, 0}, '{0, 0, 0, 0}, 20 + i, "R4", 1'b1, 1'b1);
      drain();
    end
    reg_read(4'd3, rd); check("R10", rd, 32'(s_wr));
    reg_read(4'd7, rd); check("R10", rd, 32'(d_wr));

    // R12: zero source ring size blocks new work
    reg_write(4'd1, 32'd0);
    d0 = done_cnt;
    stage(1, '{8, 0, 0, 0}, '{1, 0, 0, 0}, 40, "R12", 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    check("R12", 32'(done_cnt), 32'(d0));
    reg_read(4'd3, rd); check("R12", rd, 32'((s_wr + 3) % 4));
    reg_write(4'd1, 32'd4);
    drain();
    reg_read(4'd3, rd); check("R12", rd, 32'(s_wr));

    finish_run();
  end
endmodule